// File: doc/BRIEF.md
# Dual-Address I2C Bus Slave

This block is the target side of an I2C bus. It samples the bus clock and data lines through synchronizers on the system clock and finds start and stop conditions. It then takes in the first byte after each start, which is the address byte. The upper seven bits of that byte are compared with two slave addresses, and software programs each one separately. If either address matches, the block acknowledges. The eighth bit of the address byte picks the direction. A write from the master fills a receive register one byte at a time. A read from the master is served from a transmit holding register that feeds the shift register.

Each address has its own sticky recognition flag. A flag is cleared only by a read that returns it as 1, followed by a write of 0. A small register port gives the CPU access to both address registers, the flag status, the holding register, the receive register and a buffer-state register. In read transfers, the CPU can refill the holding register while a byte is still shifting out, so consecutive bytes go out with no idle clocks between them.

Top module: `i2c_dual_addr_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high, both seen on the synchronized lines. A start at any point, including a repeated start in mid-transfer, restarts address reception at bit 0.
- R2: The upper 7 bits of the first byte after a start are compared with address register A (offset 0, bits 6:0) and address register B (offset 1, bits 6:0). On a match with either, SDA is pulled low during the 9th clock. With no match, SDA stays released for the address and for every byte after it until the next start, and the receive register does not change.
- R3: The status register (offset 2) holds flag A in bit 7 and flag B in bit 6. A matching address frame sets the flag of each address that matched, so both flags are set if both addresses are equal. A flag stays set across later frames.
- R4: A flag clears only when a write of 0 to its bit follows a status read that returned the flag as 1. A write of 0 without such a read leaves the flag set. A write of 1 leaves it set and also removes the earlier read.
- R5: Status bits 5 to 0 always read 0, and both flags are 0 after reset.
- R6: The block only pulls SDA low. It starts pulling SDA low only while SCL is low.
- R7: In a write transfer (direction bit 0), each received byte is copied to the receive register (offset 4) at the end of its 8th bit and is acknowledged. This sets the receive-full bit (offset 5, bit 1). A CPU read of offset 4 clears receive-full.
- R8: CPU writes to the receive register (offset 4) have no effect.
- R9: In a read transfer (direction bit 1), the holding register (offset 3) is loaded into the shift register at the end of the address acknowledge and is sent MSB first. The transmit-empty bit (offset 5, bit 0) goes to 1 on that load and to 0 on a CPU write of offset 3.
- R10: A byte written to the holding register while the previous byte is shifting is sent immediately after the master acknowledges that byte. A master not-acknowledge ends the transfer and releases SDA.
- R11: After a repeated start, address comparison runs again, and flags set earlier in the transfer stay set.
- R12: After reset, SDA is released, transmit-empty is 1 and receive-full is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_addr | input | 3 | Register offset for CPU access |
| reg_wr | input | 1 | CPU write strobe |
| reg_rd | input | 1 | CPU read strobe (clears flags and buffer state where stated) |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | CPU read data for the addressed register |

## Verification
Some rules are checked on every cycle. The data line is never newly pulled low while SCL is high. A flag never falls unless a qualifying read came first. Receive-full holds until the receive register is read. A holding-register write always clears transmit-empty. Status bits 5 to 0 read as 0. CPU writes never alter the receive register. Other behaviour only shows in the bench's bus scenarios: which address byte earns an acknowledge, the bytes that come out MSB first, back-to-back transmission after a mid-byte refill, and re-arming after a repeated start.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int DATA_W   = 8;
  localparam int SADDR_W  = 7;
  localparam int REG_AW   = 3;
  localparam int NUM_ADDR = 2;
  localparam int CNT_W    = $clog2(DATA_W + 1);

  localparam logic [REG_AW-1:0] OFS_ADDR_A = 3'd0;
  localparam logic [REG_AW-1:0] OFS_ADDR_B = 3'd1;
  localparam logic [REG_AW-1:0] OFS_STATUS = 3'd2;
  localparam logic [REG_AW-1:0] OFS_TXHOLD = 3'd3;
  localparam logic [REG_AW-1:0] OFS_RXDATA = 3'd4;
  localparam logic [REG_AW-1:0] OFS_BUFST  = 3'd5;

  typedef enum logic [2:0] {
    LK_IDLE, LK_ADDR, LK_ADDR_ACK, LK_RX, LK_RX_ACK, LK_TX, LK_TX_ACK
  } link_state_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh_q, scl_sh_d, sda_sh_q, sda_sh_d;
  logic scl_prev_q, sda_prev_q;

  always_comb begin
    scl_sh_d = {scl_sh_q[STAGES-2:0], scl_in};
    sda_sh_d = {sda_sh_q[STAGES-2:0], sda_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q   <= '1;
      sda_sh_q   <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sh_q   <= scl_sh_d;
      sda_sh_q   <= sda_sh_d;
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_s     = scl_sh_q[STAGES-1];
  assign sda_s     = sda_sh_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/i2cs_link_fsm.sv
module i2cs_link_fsm
  import i2cs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_s,
  input  logic                sda_s,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_det,
  input  logic                stop_det,
  input  logic [SADDR_W-1:0]  addr_a,
  input  logic [SADDR_W-1:0]  addr_b,
  input  logic [DATA_W-1:0]   hold_data,
  output logic                sda_oe,
  output logic [NUM_ADDR-1:0] match,
  output logic                tx_load,
  output logic                rx_push,
  output logic [DATA_W-1:0]   rx_byte
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  link_state_t       state_q, state_d;
  logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              rw_q, rw_d, mack_q, mack_d, oe_q, oe_d;
  logic [NUM_ADDR-1:0] hit;

  always_comb begin
    hit[0] = (shift_q[DATA_W-1:1] == addr_a);
    hit[1] = (shift_q[DATA_W-1:1] == addr_b);
  end

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    shift_d  = shift_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    oe_d     = oe_q;
    match    = '0;
    tx_load  = 1'b0;
    rx_push  = 1'b0;
    if (stop_det) begin
      state_d = LK_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d  = LK_ADDR;
      bitcnt_d = '0;
      oe_d     = 1'b0;
    end else begin
      unique case (state_q)
        LK_ADDR, LK_RX: begin
          if (scl_rise && bitcnt_q != LAST_BIT) begin
            shift_d  = {shift_q[DATA_W-2:0], sda_s};
            bitcnt_d = bitcnt_q + 1'b1;
          end else if (scl_fall && bitcnt_q == LAST_BIT) begin
            if (state_q == LK_RX) begin
              rx_push = 1'b1;
              oe_d    = 1'b1;
              state_d = LK_RX_ACK;
            end else if (|hit) begin
              match   = hit;
              oe_d    = 1'b1;
              rw_d    = shift_q[0];
              state_d = LK_ADDR_ACK;
            end else begin
              state_d = LK_IDLE;
            end
          end
        end
        LK_ADDR_ACK: begin
          if (scl_fall) begin
            bitcnt_d = '0;
            if (rw_q) begin
              shift_d = hold_data;
              tx_load = 1'b1;
              oe_d    = ~hold_data[DATA_W-1];
              state_d = LK_TX;
            end else begin
              oe_d    = 1'b0;
              state_d = LK_RX;
            end
          end
        end
        LK_RX_ACK: begin
          if (scl_fall) begin
            oe_d     = 1'b0;
            bitcnt_d = '0;
            state_d  = LK_RX;
          end
        end
        LK_TX: begin
          if (scl_rise && bitcnt_q != LAST_BIT) begin
            bitcnt_d = bitcnt_q + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt_q == LAST_BIT) begin
              oe_d    = 1'b0;
              state_d = LK_TX_ACK;
            end else begin
              shift_d = {shift_q[DATA_W-2:0], 1'b0};
              oe_d    = ~shift_q[DATA_W-2];
            end
          end
        end
        LK_TX_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            bitcnt_d = '0;
            if (mack_q) begin
              shift_d = hold_data;
              tx_load = 1'b1;
              oe_d    = ~hold_data[DATA_W-1];
              state_d = LK_TX;
            end else begin
              oe_d    = 1'b0;
              state_d = LK_IDLE;
            end
          end
        end
        default: begin
          state_d = LK_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= LK_IDLE;
      bitcnt_q <= '0;
      shift_q  <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shift_q  <= shift_d;
      rw_q     <= rw_d;
      mack_q   <= mack_d;
      oe_q     <= oe_d;
    end
  end

  assign sda_oe  = oe_q;
  assign rx_byte = shift_q;

  // R6: a new pull-down of SDA only begins during the SCL low phase
  assert_drive_low_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !$past(oe_q)) |-> !scl_s);
endmodule

// File: rtl/i2cs_sticky_flag.sv
module i2cs_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wr_val_i,
  output logic flag_o
);
  logic flag_q, flag_d, armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (wr_i)
      armed_d = 1'b0;
    else if (rd_i && flag_q)
      armed_d = 1'b1;

    flag_d = flag_q;
    if (set_i)
      flag_d = 1'b1;
    else if (wr_i && armed_q && !wr_val_i)
      flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;

  // R4: a flag may only fall after a read that saw it set
  assert_clear_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(armed_q));
endmodule

// File: rtl/i2c_dual_addr_slave.sv
module i2c_dual_addr_slave
  import i2cs_pkg::*;
#(
  parameter logic [SADDR_W-1:0] ADDR_A_RST  = '0,
  parameter logic [SADDR_W-1:0] ADDR_B_RST  = '0,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [1:0] rst_sh_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_i_n = rst_sh_q[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  logic [SADDR_W-1:0]  addr_a_q, addr_a_d, addr_b_q, addr_b_d;
  logic [DATA_W-1:0]   hold_q, hold_d, rxd_q, rxd_d, rx_byte;
  logic                tx_empty_q, tx_empty_d, rx_full_q, rx_full_d;
  logic [NUM_ADDR-1:0] match, flags;
  logic                tx_load, rx_push;

  i2cs_link_fsm u_link (
    .clk(clk), .rst_n(rst_i_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .addr_a(addr_a_q), .addr_b(addr_b_q), .hold_data(hold_q),
    .sda_oe(sda_oe), .match(match), .tx_load(tx_load),
    .rx_push(rx_push), .rx_byte(rx_byte));

  logic wr_a, wr_b, wr_st, rd_st, wr_tx, wr_rx, rd_rx;
  assign wr_a  = reg_wr && reg_addr == OFS_ADDR_A;
  assign wr_b  = reg_wr && reg_addr == OFS_ADDR_B;
  assign wr_st = reg_wr && reg_addr == OFS_STATUS;
  assign rd_st = reg_rd && reg_addr == OFS_STATUS;
  assign wr_tx = reg_wr && reg_addr == OFS_TXHOLD;
  assign wr_rx = reg_wr && reg_addr == OFS_RXDATA;
  assign rd_rx = reg_rd && reg_addr == OFS_RXDATA;

  for (genvar i = 0; i < NUM_ADDR; i++) begin : g_flag
    i2cs_sticky_flag u_flag (
      .clk(clk), .rst_n(rst_i_n), .set_i(match[i]), .rd_i(rd_st),
      .wr_i(wr_st), .wr_val_i(reg_wdata[DATA_W-1-i]), .flag_o(flags[i]));
  end

  always_comb begin
    addr_a_d   = wr_a ? reg_wdata[SADDR_W-1:0] : addr_a_q;
    addr_b_d   = wr_b ? reg_wdata[SADDR_W-1:0] : addr_b_q;
    hold_d     = wr_tx ? reg_wdata : hold_q;
    rxd_d      = rx_push ? rx_byte : rxd_q;
    tx_empty_d = tx_empty_q;
    if (wr_tx)        tx_empty_d = 1'b0;
    else if (tx_load) tx_empty_d = 1'b1;
    rx_full_d = rx_full_q;
    if (rx_push)    rx_full_d = 1'b1;
    else if (rd_rx) rx_full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      addr_a_q   <= ADDR_A_RST;
      addr_b_q   <= ADDR_B_RST;
      hold_q     <= '0;
      rxd_q      <= '0;
      tx_empty_q <= 1'b1;
      rx_full_q  <= 1'b0;
    end else begin
      addr_a_q   <= addr_a_d;
      addr_b_q   <= addr_b_d;
      hold_q     <= hold_d;
      rxd_q      <= rxd_d;
      tx_empty_q <= tx_empty_d;
      rx_full_q  <= rx_full_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_ADDR_A: reg_rdata = {1'b0, addr_a_q};
      OFS_ADDR_B: reg_rdata = {1'b0, addr_b_q};
      OFS_STATUS: reg_rdata = {flags[0], flags[1], 6'b0};
      OFS_TXHOLD: reg_rdata = hold_q;
      OFS_RXDATA: reg_rdata = rxd_q;
      OFS_BUFST:  reg_rdata = {6'b0, rx_full_q, tx_empty_q};
      default:    reg_rdata = '0;
    endcase
  end

  // R5: low status bits are never set
  assert_status_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (reg_addr == OFS_STATUS) |-> (reg_rdata[5:0] == 6'b0));
  // R7: receive-full persists until the receive register is read
  assert_rx_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rx_full_q && !rd_rx) |=> rx_full_q);
  // R8: CPU writes leave the receive register untouched
  assert_rx_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_rx && !rx_push) |=> $stable(rxd_q));
  // R9: a holding-register write always marks it occupied
  assert_tx_write_fills_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_tx |=> !tx_empty_q);
endmodule

// File: tb/i2c_dual_addr_slave_test.sv
module i2c_dual_addr_slave_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic       sda_oe, sda_line;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_dual_addr_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  // vector: {address byte, expected ack, expected flag A, expected flag B}
  localparam logic [10:0] VEC [4] = '{
    {8'h54, 1'b1, 1'b1, 1'b0},
    {8'hA2, 1'b1, 1'b0, 1'b1},
    {8'h12, 1'b0, 1'b0, 1'b0},
    {8'h56, 1'b0, 1'b0, 1'b0}
  };

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cpu_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hw(6);
    m_scl = 1'b1; hw(6);
    m_sda = 1'b0; hw(6);
    m_scl = 1'b0; hw(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hw(6);
    m_scl = 1'b1; hw(6);
    m_sda = 1'b1; hw(8);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; hw(6);
    m_scl = 1'b1; hw(8);
    m_scl = 1'b0; hw(2);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; hw(6);
    m_scl = 1'b1; hw(4);
    b = sda_line; hw(4);
    m_scl = 1'b0; hw(2);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~ack);
  endtask

  task automatic clear_flags();
    logic [7:0] t;
    cpu_read(3'd2, t);
    cpu_write(3'd2, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       ack;
    hw(5);
    rst_n = 1'b1;
    hw(5);

    // reset state
    check("R12 sda released", {7'b0, sda_oe}, 8'h00);
    cpu_read(3'd2, d); check("R5 status at reset", d, 8'h00);
    cpu_read(3'd5, d); check("R12 buffer state at reset", d, 8'h01);

    cpu_write(3'd0, 8'h2A);
    cpu_write(3'd1, 8'h51);
    cpu_read(3'd0, d); check("R2 address A readback", d, 8'h2A);

    // table of address frames
    for (int v = 0; v < 4; v++) begin
      bus_start();
      send_byte(VEC[v][10:3], ack);
      bus_stop();
      check($sformatf("R2 ack vector %0d", v), {7'b0, ack}, {7'b0, VEC[v][2]});
      cpu_read(3'd2, d);
      check($sformatf("R3 flags vector %0d", v), d, {VEC[v][1], VEC[v][0], 6'b0});
      cpu_write(3'd2, 8'h00);
      cpu_read(3'd2, d);
      check($sformatf("R4 cleared vector %0d", v), d, 8'h00);
    end

    // R7 write transfer into receive register
    bus_start();
    send_byte(8'h54, ack);
    send_byte(8'h3C, ack);
    check("R7 data byte acked", {7'b0, ack}, 8'h01);
    cpu_read(3'd5, d); check("R7 receive-full set", d, 8'h03);
    cpu_read(3'd4, d); check("R7 received byte", d, 8'h3C);
    cpu_read(3'd5, d); check("R7 receive-full cleared by read", d, 8'h01);
    send_byte(8'hC5, ack);
    bus_stop();
    cpu_write(3'd4, 8'hFF);
    cpu_read(3'd4, d); check("R8 receive register write ignored", d, 8'hC5);

    // R4 clear protocol, flag A is set from the frame above
    cpu_write(3'd2, 8'h00);
    cpu_read(3'd2, d); check("R4 write 0 without read keeps flag", d, 8'h80);
    cpu_write(3'd2, 8'h80);
    cpu_read(3'd2, d); check("R4 write 1 keeps flag", d, 8'h80);
    cpu_write(3'd2, 8'h00);
    cpu_read(3'd2, d); check("R4 read then write 0 clears", d, 8'h00);

    // R2 unmatched frame: data ignored
    bus_start();
    send_byte(8'h12, ack);
    send_byte(8'h77, ack);
    check("R2 data after unmatched address not acked", {7'b0, ack}, 8'h00);
    bus_stop();
    cpu_read(3'd4, d); check("R2 receive register unchanged", d, 8'hC5);

    // R3 both addresses equal
    cpu_write(3'd1, 8'h2A);
    bus_start();
    send_byte(8'h54, ack);
    bus_stop();
    cpu_read(3'd2, d); check("R3 both flags on equal addresses", d, 8'hC0);
    cpu_write(3'd2, 8'h00);
    cpu_write(3'd1, 8'h51);

    // R9 R10 read transfer with refill during shifting
    cpu_write(3'd3, 8'h96);
    cpu_read(3'd5, d); check("R9 holding write clears empty", d, 8'h00);
    bus_start();
    send_byte(8'h55, ack);
    check("R9 read address acked", {7'b0, ack}, 8'h01);
    hw(6);
    cpu_read(3'd5, d); check("R9 empty after load", d, 8'h01);
    cpu_write(3'd3, 8'h5A);
    recv_byte(d, 1'b1); check("R9 first byte MSB first", d, 8'h96);
    recv_byte(d, 1'b0); check("R10 refilled byte back to back", d, 8'h5A);
    check("R10 released after nack", {7'b0, sda_oe}, 8'h00);
    bus_stop();
    clear_flags();

    // R1 R11 repeated start
    bus_start();
    send_byte(8'h12, ack);
    check("R1 unmatched before repeated start", {7'b0, ack}, 8'h00);
    bus_start();
    send_byte(8'hA2, ack);
    check("R11 match after repeated start", {7'b0, ack}, 8'h01);
    bus_stop();
    cpu_read(3'd2, d); check("R11 flag B after repeated start", d, 8'h40);
    cpu_write(3'd2, 8'h00);

    bus_start();
    send_byte(8'h54, ack);
    send_byte(8'h11, ack);
    bus_start();
    send_byte(8'hA2, ack);
    check("R1 restart mid transfer acked", {7'b0, ack}, 8'h01);
    send_byte(8'h22, ack);
    bus_stop();
    cpu_read(3'd2, d); check("R11 earlier flag kept", d, 8'hC0);
    cpu_read(3'd4, d); check("R7 byte after restart", d, 8'h22);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule